// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block holds a small set of waiting operations in front of a single integer ALU. An issuer hands it one operation per cycle: a 3-bit opcode and two source operands. Each operand arrives either as a ready value (tag zero) or as the nonzero tag of the producer that will compute it later. The bank reports which station the next issue will occupy (`allocTag`) and raises `issueStall` when no station is free.

Stations with a pending operand watch every result broadcast, meaning each external snoop bus plus the bank's own result output. When a tag matches, the station captures the value. If an operand's producer is broadcasting in the same cycle the operation issues, the value is taken straight from the bus. Each cycle, the lowest-numbered station whose operands are all present is sent to a one-cycle ALU. The result is registered and broadcast on the next cycle, labelled with that station's tag. In that same cycle the station becomes free again.

Stations carry tags `STATION_BASE` to `STATION_BASE+NUM_ENTRIES-1`. Tag 0 is never a producer.

Top module: `rs_bank`

## Requirements
- R1: After reset, no station is busy, `resValid` is 0, `issueStall` is 0 and `allocTag` equals `STATION_BASE` (1 by default).
- R2: An operation issued with both tags 0 in cycle c is broadcast in cycle c+2 on `resValid`/`resTag`/`resData`. `resTag` is the tag of the station it occupied.
- R3: Opcodes: 0 add, 1 subtract (A-B), 2 AND, 3 OR, 4 XOR, 5 unsigned less-than (1 if A<B, else 0), 6 pass A, 7 pass B. Results wrap modulo 2^DATA_W.
- R4: A station whose operand tag is nonzero never executes. Broadcasts carrying a different tag leave it waiting.
- R5: A broadcast in cycle c, on any snoop bus, whose tag matches a waiting operand is captured. The station's result appears in cycle c+2 if no other operand is pending.
- R6: An operand whose tag is being broadcast, on a snoop bus or on the bank's own result, in the same cycle it issues is taken from the bus. The operation then has the latency of R2.
- R7: When several stations are ready in the same cycle, the lowest-numbered one executes first. One result is broadcast per cycle, in station order.
- R8: A station becomes free in the cycle its result is broadcast. `allocTag` names it again from that cycle on, and `issueStall` drops if it was high.
- R9: When all stations are busy, `issueStall` is 1 and an issue attempt is ignored: it produces no result and occupies no station.
- R10: The bank snoops its own result output, so an operation waiting on a tag of this bank receives that result.
- R11: `allocTag` is the tag of the lowest-numbered free station, and the next accepted issue occupies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An operation is offered this cycle |
| issueOp | input | 3 | Opcode (see R3) |
| issueTagA | input | TAG_W | Producer tag of operand A, 0 when the value is ready |
| issueValA | input | DATA_W | Operand A value, used when its tag is 0 |
| issueTagB | input | TAG_W | Producer tag of operand B, 0 when the value is ready |
| issueValB | input | DATA_W | Operand B value, used when its tag is 0 |
| issueStall | output | 1 | All stations busy; an offered operation is dropped |
| allocTag | output | TAG_W | Tag of the station the next issue occupies |
| snoopValid | input | NUM_SNOOP | Per-bus broadcast valid |
| snoopTag | input | NUM_SNOOP*TAG_W | Per-bus producer tag, bus 0 in the low bits |
| snoopData | input | NUM_SNOOP*DATA_W | Per-bus result value, bus 0 in the low bits |
| resValid | output | 1 | The bank broadcasts a result |
| resTag | output | TAG_W | Tag of the station that produced the result |
| resData | output | DATA_W | ALU result |

## Verification
The in-RTL assertions check four things on every cycle. A granted station has no pending tag. A grant is always followed by a broadcast. A grant never passes over a lower-numbered ready station. A station is busy after allocation and free after its broadcast. They also check that a full bank never gains occupancy. Other behaviour shows only in the directed scenarios: the arithmetic of each opcode, capture on a matching tag versus a foreign one, same-cycle capture at issue from both an external bus and the bank's own result, the exact result latencies, the in-order drain of four stations woken by one broadcast, and a dropped issue while full.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Widest station index the strobe struct can carry (up to 16 stations).
  localparam int unsigned IDX_MAX_W = 4;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_SLTU  = 3'd5,
    OP_PASSA = 3'd6,
    OP_PASSB = 3'd7
  } rs_op_e;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic                 allocEn;
    logic [IDX_MAX_W-1:0] allocIdx;
    logic                 grantEn;
    logic [IDX_MAX_W-1:0] grantIdx;
  } rs_strobe_t;

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES  = 4,
  parameter int unsigned TAG_W        = 4,
  parameter int unsigned STATION_BASE = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   issueValid,
  input  logic [NUM_ENTRIES-1:0] entryReady,
  output rs_strobe_t             strobe,
  output logic                   issueStall,
  output logic [TAG_W-1:0]       allocTag
);

  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] busyQ;
  logic [NUM_ENTRIES-1:0] busyNext;
  logic [NUM_ENTRIES-1:0] freeVec;
  logic [NUM_ENTRIES-1:0] readyVec;
  logic [IDX_W-1:0]       allocLoc;
  logic [IDX_W-1:0]       grantLoc;
  logic                   allocAny;
  logic                   grantAny;
  logic                   allocEn;

  assign freeVec  = ~busyQ;
  assign readyVec = busyQ & entryReady;

  // Lowest-index free station and lowest-index ready station.
  always_comb begin
    allocAny = 1'b0;
    allocLoc = '0;
    grantAny = 1'b0;
    grantLoc = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        allocAny = 1'b1;
        allocLoc = IDX_W'(i);
      end
      if (readyVec[i]) begin
        grantAny = 1'b1;
        grantLoc = IDX_W'(i);
      end
    end
  end

  assign allocEn    = issueValid && allocAny;
  assign issueStall = ~allocAny;
  assign allocTag   = TAG_W'(STATION_BASE) + TAG_W'(allocLoc);

  always_comb begin
    strobe          = '0;
    strobe.allocEn  = allocEn;
    strobe.allocIdx = IDX_MAX_W'(allocLoc);
    strobe.grantEn  = grantAny;
    strobe.grantIdx = IDX_MAX_W'(grantLoc);
  end

  always_comb begin
    busyNext = busyQ;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grantAny && (grantLoc == IDX_W'(i))) busyNext[i] = 1'b0;
      if (allocEn && (allocLoc == IDX_W'(i)))  busyNext[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= busyNext;
  end

  AST_LOWEST_READY_WINS: assert property (@(posedge clk) disable iff (!rstN)
    grantAny |-> ((readyVec & ((NUM_ENTRIES'(1) << grantLoc) - NUM_ENTRIES'(1))) == '0)); // R7

  AST_FREE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    grantAny |=> (busyQ[$past(grantLoc)] == 1'b0)); // R8

  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    issueStall |=> ($countones(busyQ) <= $past($countones(busyQ)))); // R9

  AST_ALLOC_OCCUPIES: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |=> busyQ[$past(allocLoc)]); // R11

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES  = 4,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned TAG_W        = 4,
  parameter int unsigned NUM_SNOOP    = 2,
  parameter int unsigned STATION_BASE = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rs_strobe_t                    strobe,
  input  logic [2:0]                    issueOp,
  input  logic [TAG_W-1:0]              issueTagA,
  input  logic [DATA_W-1:0]             issueValA,
  input  logic [TAG_W-1:0]              issueTagB,
  input  logic [DATA_W-1:0]             issueValB,
  input  logic [NUM_SNOOP-1:0]          snoopValid,
  input  logic [NUM_SNOOP*TAG_W-1:0]    snoopTag,
  input  logic [NUM_SNOOP*DATA_W-1:0]   snoopData,
  output logic [NUM_ENTRIES-1:0]        entryReady,
  output logic                          resValid,
  output logic [TAG_W-1:0]              resTag,
  output logic [DATA_W-1:0]             resData
);

  // Snooped buses: external ones first, the bank's own result last.
  localparam int unsigned NB = NUM_SNOOP + 1;

  logic [NB-1:0]        busV;
  logic [NB*TAG_W-1:0]  busT;
  logic [NB*DATA_W-1:0] busD;

  assign busV = {resValid, snoopValid};
  assign busT = {resTag, snoopTag};
  assign busD = {resData, snoopData};

  // Returns {hit, value}; the lowest-numbered matching bus wins.
  function automatic logic [DATA_W:0] busLookup(
    input logic [TAG_W-1:0]     tag,
    input logic [NB-1:0]        v,
    input logic [NB*TAG_W-1:0]  t,
    input logic [NB*DATA_W-1:0] d
  );
    logic [DATA_W:0] r;
    r = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (v[b] && (t[b*TAG_W +: TAG_W] == tag)) r = {1'b1, d[b*DATA_W +: DATA_W]};
    end
    return r;
  endfunction

  // Issue-time operand resolution, including same-cycle bus capture.
  logic [DATA_W:0]   issHitA;
  logic [DATA_W:0]   issHitB;
  logic [TAG_W-1:0]  inTagA;
  logic [TAG_W-1:0]  inTagB;
  logic [DATA_W-1:0] inValA;
  logic [DATA_W-1:0] inValB;

  assign issHitA = busLookup(issueTagA, busV, busT, busD);
  assign issHitB = busLookup(issueTagB, busV, busT, busD);

  always_comb begin
    inTagA = issueTagA;
    inValA = issueValA;
    if (issueTagA != '0 && issHitA[DATA_W]) begin
      inTagA = '0;
      inValA = issHitA[DATA_W-1:0];
    end
    inTagB = issueTagB;
    inValB = issueValB;
    if (issueTagB != '0 && issHitB[DATA_W]) begin
      inTagB = '0;
      inValB = issHitB[DATA_W-1:0];
    end
  end

  logic [2:0]        opArr   [NUM_ENTRIES];
  logic [TAG_W-1:0]  tagAArr [NUM_ENTRIES];
  logic [TAG_W-1:0]  tagBArr [NUM_ENTRIES];
  logic [DATA_W-1:0] valAArr [NUM_ENTRIES];
  logic [DATA_W-1:0] valBArr [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [2:0]        opQ;
    logic [TAG_W-1:0]  tagAQ;
    logic [TAG_W-1:0]  tagBQ;
    logic [DATA_W-1:0] valAQ;
    logic [DATA_W-1:0] valBQ;
    logic              loadHere;
    logic [DATA_W:0]   hitA;
    logic [DATA_W:0]   hitB;

    assign loadHere = strobe.allocEn && (strobe.allocIdx == IDX_MAX_W'(e));
    assign hitA     = busLookup(tagAQ, busV, busT, busD);
    assign hitB     = busLookup(tagBQ, busV, busT, busD);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opQ   <= '0;
        tagAQ <= '0;
        tagBQ <= '0;
        valAQ <= '0;
        valBQ <= '0;
      end else if (loadHere) begin
        opQ   <= issueOp;
        tagAQ <= inTagA;
        valAQ <= inValA;
        tagBQ <= inTagB;
        valBQ <= inValB;
      end else begin
        if (tagAQ != '0 && hitA[DATA_W]) begin
          tagAQ <= '0;
          valAQ <= hitA[DATA_W-1:0];
        end
        if (tagBQ != '0 && hitB[DATA_W]) begin
          tagBQ <= '0;
          valBQ <= hitB[DATA_W-1:0];
        end
      end
    end

    assign entryReady[e] = (tagAQ == '0) && (tagBQ == '0);
    assign opArr[e]      = opQ;
    assign tagAArr[e]    = tagAQ;
    assign tagBArr[e]    = tagBQ;
    assign valAArr[e]    = valAQ;
    assign valBArr[e]    = valBQ;
  end

  // Operand select for the granted station.
  logic [2:0]        selOp;
  logic [TAG_W-1:0]  selTagA;
  logic [TAG_W-1:0]  selTagB;
  logic [DATA_W-1:0] selA;
  logic [DATA_W-1:0] selB;

  always_comb begin
    selOp   = '0;
    selTagA = '0;
    selTagB = '0;
    selA    = '0;
    selB    = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (strobe.grantIdx == IDX_MAX_W'(e)) begin
        selOp   = opArr[e];
        selTagA = tagAArr[e];
        selTagB = tagBArr[e];
        selA    = valAArr[e];
        selB    = valBArr[e];
      end
    end
  end

  logic [DATA_W-1:0] aluOut;

  always_comb begin
    case (rs_op_e'(selOp))
      OP_ADD:   aluOut = selA + selB;
      OP_SUB:   aluOut = selA - selB;
      OP_AND:   aluOut = selA & selB;
      OP_OR:    aluOut = selA | selB;
      OP_XOR:   aluOut = selA ^ selB;
      OP_SLTU:  aluOut = (selA < selB) ? DATA_W'(1) : '0;
      OP_PASSA: aluOut = selA;
      default:  aluOut = selB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resTag   <= '0;
      resData  <= '0;
    end else begin
      resValid <= strobe.grantEn;
      if (strobe.grantEn) begin
        resTag  <= TAG_W'(STATION_BASE) + TAG_W'(strobe.grantIdx);
        resData <= aluOut;
      end
    end
  end

  AST_GRANT_OPERANDS_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grantEn |-> (selTagA == '0 && selTagB == '0)); // R4

  AST_GRANT_BROADCASTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grantEn |=> resValid); // R2

endmodule

// File: rtl/rs_bank.sv
module rs_bank
  import rs_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES  = 4,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned TAG_W        = 4,
  parameter int unsigned NUM_SNOOP    = 2,
  parameter int unsigned STATION_BASE = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        issueValid,
  input  logic [2:0]                  issueOp,
  input  logic [TAG_W-1:0]            issueTagA,
  input  logic [DATA_W-1:0]           issueValA,
  input  logic [TAG_W-1:0]            issueTagB,
  input  logic [DATA_W-1:0]           issueValB,
  output logic                        issueStall,
  output logic [TAG_W-1:0]            allocTag,
  input  logic [NUM_SNOOP-1:0]        snoopValid,
  input  logic [NUM_SNOOP*TAG_W-1:0]  snoopTag,
  input  logic [NUM_SNOOP*DATA_W-1:0] snoopData,
  output logic                        resValid,
  output logic [TAG_W-1:0]            resTag,
  output logic [DATA_W-1:0]           resData
);

  rs_strobe_t             strobe;
  logic [NUM_ENTRIES-1:0] entryReady;

  rs_ctrl #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .TAG_W       (TAG_W),
    .STATION_BASE(STATION_BASE)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .entryReady(entryReady),
    .strobe    (strobe),
    .issueStall(issueStall),
    .allocTag  (allocTag)
  );

  rs_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .DATA_W      (DATA_W),
    .TAG_W       (TAG_W),
    .NUM_SNOOP   (NUM_SNOOP),
    .STATION_BASE(STATION_BASE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .issueOp   (issueOp),
    .issueTagA (issueTagA),
    .issueValA (issueValA),
    .issueTagB (issueTagB),
    .issueValB (issueValB),
    .snoopValid(snoopValid),
    .snoopTag  (snoopTag),
    .snoopData (snoopData),
    .entryReady(entryReady),
    .resValid  (resValid),
    .resTag    (resTag),
    .resData   (resData)
  );

endmodule

// File: tb/rs_bank_tb_top.sv
module rs_bank_tb_top;

  localparam int unsigned DATA_W = 16;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned NS     = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              issueValid = 1'b0;
  logic [2:0]        issueOp = '0;
  logic [TAG_W-1:0]  issueTagA = '0;
  logic [DATA_W-1:0] issueValA = '0;
  logic [TAG_W-1:0]  issueTagB = '0;
  logic [DATA_W-1:0] issueValB = '0;
  logic              issueStall;
  logic [TAG_W-1:0]  allocTag;
  logic [NS-1:0]        snoopValid = '0;
  logic [NS*TAG_W-1:0]  snoopTag = '0;
  logic [NS*DATA_W-1:0] snoopData = '0;
  logic              resValid;
  logic [TAG_W-1:0]  resTag;
  logic [DATA_W-1:0] resData;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rs_bank dut_i (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueTagA(issueTagA), .issueValA(issueValA),
    .issueTagB(issueTagB), .issueValB(issueValB),
    .issueStall(issueStall), .allocTag(allocTag),
    .snoopValid(snoopValid), .snoopTag(snoopTag), .snoopData(snoopData),
    .resValid(resValid), .resTag(resTag), .resData(resData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectRes(input string req, input int tag, input int data);
    chk({req, " resValid"}, 32'(resValid), 1);
    chk({req, " resTag"}, 32'(resTag), 32'(tag));
    chk({req, " resData"}, 32'(resData), 32'(data));
  endtask

  task automatic expectIdle(input string req);
    chk({req, " no result"}, 32'(resValid), 0);
  endtask

  // Offer one operation for one cycle; returns at the next falling edge.
  task automatic drvIssue(input int op, input int ta, input int va, input int tb, input int vb);
    issueValid = 1'b1;
    issueOp    = 3'(op);
    issueTagA  = TAG_W'(ta);
    issueValA  = DATA_W'(va);
    issueTagB  = TAG_W'(tb);
    issueValB  = DATA_W'(vb);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic bcast(input int bus, input int tag, input int data);
    snoopValid[bus] = 1'b1;
    snoopTag[bus*TAG_W +: TAG_W]    = TAG_W'(tag);
    snoopData[bus*DATA_W +: DATA_W] = DATA_W'(data);
    @(negedge clk);
    snoopValid = '0;
  endtask

  task automatic testReset();
    chk("R1 resValid", 32'(resValid), 0);
    chk("R1 issueStall", 32'(issueStall), 0);
    chk("R1 allocTag", 32'(allocTag), 1);
  endtask

  task automatic testBasic();
    drvIssue(0, 0, 5, 0, 7);
    @(negedge clk);
    expectRes("R2 add", 1, 12);
    @(negedge clk);
    expectIdle("R2 single result");
    chk("R8 allocTag after result", 32'(allocTag), 1);
  endtask

  task automatic testOps();
    int expv [8] = '{22, 2, 8, 14, 6, 0, 12, 10};
    for (int op = 0; op < 8; op++) begin
      drvIssue(op, 0, 12, 0, 10);
      @(negedge clk);
      expectRes($sformatf("R3 op%0d", op), 1, expv[op]);
    end
    drvIssue(5, 0, 3, 0, 9);
    @(negedge clk);
    expectRes("R3 sltu true", 1, 1);
    drvIssue(1, 0, 3, 0, 5);
    @(negedge clk);
    expectRes("R3 sub wrap", 1, 16'hFFFE);
  endtask

  task automatic testWaitSnoop();
    drvIssue(1, 9, 0, 0, 3);
    chk("R11 allocTag skips busy", 32'(allocTag), 2);
    for (int k = 0; k < 3; k++) begin
      expectIdle("R4 waiting");
      @(negedge clk);
    end
    bcast(0, 8, 77);
    expectIdle("R4 foreign tag");
    @(negedge clk);
    expectIdle("R4 foreign tag later");
    bcast(1, 9, 20);
    expectIdle("R5 capture cycle");
    @(negedge clk);
    expectRes("R5 snooped sub", 1, 17);
    @(negedge clk);
  endtask

  task automatic testSameCycle();
    snoopValid[0] = 1'b1;
    snoopTag[0 +: TAG_W]   = TAG_W'(9);
    snoopData[0 +: DATA_W] = DATA_W'(100);
    issueValid = 1'b1;
    issueOp    = 3'd0;
    issueTagA  = TAG_W'(9);
    issueValA  = '0;
    issueTagB  = '0;
    issueValB  = DATA_W'(1);
    @(negedge clk);
    issueValid = 1'b0;
    snoopValid = '0;
    @(negedge clk);
    expectRes("R6 capture at issue", 1, 101);
    @(negedge clk);
  endtask

  task automatic testFullAndOrder();
    for (int e = 1; e <= 4; e++) begin
      chk("R11 allocTag fill", 32'(allocTag), 32'(e));
      drvIssue(0, 10, 0, 0, e);
    end
    chk("R9 stall when full", 32'(issueStall), 1);
    drvIssue(0, 0, 1, 0, 1);
    expectIdle("R9 dropped issue");
    @(negedge clk);
    expectIdle("R9 dropped issue later");
    bcast(1, 10, 50);
    expectIdle("R7 wake cycle");
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      expectRes("R7 station order", e, 50 + e);
      if (e == 1) begin
        chk("R8 stall drops", 32'(issueStall), 0);
        chk("R8 allocTag freed", 32'(allocTag), 1);
      end
    end
    @(negedge clk);
    expectIdle("R9 no extra result");
  endtask

  task automatic testChain();
    drvIssue(0, 0, 2, 0, 3);
    drvIssue(0, 1, 0, 0, 10);
    expectRes("R10 producer", 1, 5);
    @(negedge clk);
    expectIdle("R10 consumer capture cycle");
    @(negedge clk);
    expectRes("R10 consumer", 2, 15);
    @(negedge clk);
    drvIssue(1, 0, 30, 0, 4);
    @(negedge clk);
    expectRes("R6 own producer", 1, 26);
    drvIssue(0, 1, 0, 0, 5);
    expectIdle("R6 own capture cycle");
    @(negedge clk);
    expectRes("R6 own bus at issue", 1, 31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testOps();
    testWaitSnoop();
    testSameCycle();
    testFullAndOrder();
    repeat (2) @(negedge clk);
    testChain();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule